// File: doc/BRIEF.md
# Multi-Digit Seven-Segment Decimal Driver

This block takes an unsigned binary integer and shows it in decimal on a row of seven-segment digits. Each digit has its own seven-line segment bus, so all digits are lit at the same time. The digit count and the output polarity are parameters. The binary input width follows from the digit count: it is the smallest integer not below 3.322 times the digit count, which gives 10 bits for the default of 3 digits.

Conversion to decimal is sequential. A shift-and-add-3 engine captures the input, spends one clock cycle per input bit, and then publishes the decimal result. Zeros above the highest non-zero digit are then turned into a non-decimal blank code. A per-digit mapper turns every code above 9 into an unlit digit. A final register drives the pins with either the active-low pattern or its inverse. A new conversion starts whenever the input differs from the value last captured, and the block always starts one after reset.

Top module: `sevseg_int_driver`

## Requirements
- R1: Digit i (i = 0 being least significant) appears on seg_o[7i+6:7i] and shows the i-th decimal digit of the captured input value, for every input from 0 up to 10^DIGITS−1.
- R2: With POL = 0 each digit field is active-low with segment a in bit 6 down to segment g in bit 0: 0=0000001, 1=1001111, 2=0010010, 3=0000110, 4=1001100, 5=0100100, 6=0100000, 7=0001111, 8=0000000, 9=0000100, and unlit is 1111111.
- R3: A digit i > 0 is unlit when it and every more significant digit are zero; a suppressed digit never shows a lit 0.
- R4: Digit 0 is never suppressed, so an input of 0 shows a single 0 in digit 0 with every other digit unlit.
- R5: A new input value sampled at clock edge k appears on seg_o after edge k+BIN_W+2, which is BIN_W+3 edges counted from k. Until then seg_o keeps the previous result.
- R6: The input is captured when a conversion starts. Changes during a conversion do not affect its result. Once it finishes, a differing input starts the next conversion on the following edge.
- R7: Any edge that samples rst_n low aborts a conversion in progress and sets every digit of seg_o unlit.
- R8: On the first edge that samples rst_n high, a conversion of the current input starts, and its result appears BIN_W+3 edges later.
- R9: With POL = 1 every segment bit is the inverse of the POL = 0 value for the same input (common cathode), unlit digits included.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| value_i | input | BIN_W | Unsigned binary value to display |
| seg_o | output | 7*DIGITS | Segment buses, 7 bits per digit, digit 0 lowest |

## Verification
Results are due BIN_W+3 rising edges after the edge that first samples a new input or a released reset. The bench drives just after an edge and samples one edge before that deadline, where the old result must still be present, and again exactly at the deadline. When the input changes during a conversion, the second value is due 2·BIN_W+5 edges after the first. That case is checked at both neighbouring cycles too, and so is a restart after a reset in mid-conversion.

// File: rtl/sevseg_pkg.sv
// Package: shared types and helpers for the seven-segment decimal driver.
// Assumes: callers size the binary input with bin_width().
package sevseg_pkg;

    // Converter sequencing states
    typedef enum logic [1:0] {
        CV_IDLE   = 2'd0,
        CV_SHIFT  = 2'd1,
        CV_FINISH = 2'd2
    } conv_state_t;

    // Active-low pattern of an unlit digit
    localparam logic [6:0] GLYPH_OFF_AL = 7'b1111111;

    // Blank code forced onto suppressed digits (any code above 9 is unlit)
    localparam logic [3:0] CODE_BLANK = 4'hF;

    // Smallest integer not below 3.322 * digits
    function automatic int bin_width(input int digits);
        return (digits * 3322 + 999) / 1000;
    endfunction

endpackage

// File: rtl/sevseg_bin2bcd.sv
// Sequential binary-to-BCD converter (shift and add 3).
// Does: captures value_i when idle and the value is new (or the first after
// reset), performs BIN_W correction-and-shift steps, then publishes the
// BCD result on bcd_o in a FINISH cycle. Total busy time is BIN_W+1 cycles.
// Assumes: reset is synchronous and active low; bcd_o reads all-ones
// (blank codes) after reset until the first result.
module sevseg_bin2bcd
    import sevseg_pkg::*;
#(
    parameter int DIGITS = 3,
    parameter int BIN_W  = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [BIN_W-1:0]      value_i,
    output logic [4*DIGITS-1:0]   bcd_o,
    output logic                  busy_o,
    output logic                  done_o
);
    localparam int BCD_W = 4 * DIGITS;
    localparam int CNT_W = (BIN_W > 1) ? $clog2(BIN_W) : 1;
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(BIN_W - 1);

    conv_state_t         state_q;
    logic [CNT_W-1:0]    step_q;
    logic [BIN_W-1:0]    bin_sh_q;
    logic [BCD_W-1:0]    bcd_sh_q;
    logic [BCD_W-1:0]    bcd_adj;
    logic [BIN_W-1:0]    last_val_q;
    logic                first_q;
    logic [BCD_W-1:0]    bcd_q;
    logic                start;

    // Start a conversion when idle and either just out of reset or the input moved
    assign start = (state_q == CV_IDLE) && (first_q || (value_i != last_val_q));

    // Add 3 to every nibble that is 5 or more before the next shift
    for (genvar n = 0; n < DIGITS; n++) begin : g_adj
        always_comb begin
            if (bcd_sh_q[4*n +: 4] >= 4'd5)
                bcd_adj[4*n +: 4] = bcd_sh_q[4*n +: 4] + 4'd3;
            else
                bcd_adj[4*n +: 4] = bcd_sh_q[4*n +: 4];
        end
    end

    // Sequencer: capture, shift BIN_W times, publish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= CV_IDLE;
            step_q     <= '0;
            bin_sh_q   <= '0;
            bcd_sh_q   <= '0;
            last_val_q <= '0;
            first_q    <= 1'b1;
            bcd_q      <= '1;
        end else begin
            case (state_q)
                CV_IDLE: begin
                    if (start) begin
                        bin_sh_q   <= value_i;
                        bcd_sh_q   <= '0;
                        last_val_q <= value_i;
                        first_q    <= 1'b0;
                        step_q     <= '0;
                        state_q    <= CV_SHIFT;
                    end
                end
                CV_SHIFT: begin
                    bcd_sh_q <= {bcd_adj[BCD_W-2:0], bin_sh_q[BIN_W-1]};
                    bin_sh_q <= bin_sh_q << 1;
                    step_q   <= step_q + 1'b1;
                    if (step_q == LAST_STEP)
                        state_q <= CV_FINISH;
                end
                CV_FINISH: begin
                    bcd_q   <= bcd_sh_q;
                    state_q <= CV_IDLE;
                end
                default: state_q <= CV_IDLE;
            endcase
        end
    end

    assign bcd_o  = bcd_q;
    assign busy_o = (state_q != CV_IDLE);
    assign done_o = (state_q == CV_FINISH);

endmodule

// File: rtl/sevseg_zero_blank.sv
// Leading-zero suppression.
// Does: replaces every digit above digit 0 that is zero, with all higher
// digits zero, by the blank code. Digit 0 always passes through.
// Assumes: purely combinational; blank code 4'hF is unlit in the mapper.
module sevseg_zero_blank
    import sevseg_pkg::*;
#(
    parameter int DIGITS = 3
) (
    input  logic [4*DIGITS-1:0] bcd_i,
    output logic [4*DIGITS-1:0] bcd_o
);
    logic [DIGITS-1:0] nz_above;   // digit i or any higher digit is non-zero

    // OR chain from the most significant digit downwards
    assign nz_above[DIGITS-1] = |bcd_i[4*(DIGITS-1) +: 4];
    for (genvar i = DIGITS - 2; i >= 0; i--) begin : g_chain
        assign nz_above[i] = nz_above[i+1] | (|bcd_i[4*i +: 4]);
    end

    // Digit 0 always shown; higher digits blanked when nothing non-zero is at or above
    assign bcd_o[3:0] = bcd_i[3:0];
    for (genvar i = 1; i < DIGITS; i++) begin : g_sel
        assign bcd_o[4*i +: 4] = nz_above[i] ? bcd_i[4*i +: 4] : CODE_BLANK;
    end

endmodule

// File: rtl/sevseg_glyph.sv
// BCD digit to segment pattern mapper.
// Does: maps 0..9 to an active-low a..g pattern (a in bit 6), any other
// code to unlit, then inverts the result when POL is 1.
// Assumes: purely combinational.
module sevseg_glyph
    import sevseg_pkg::*;
#(
    parameter int POL = 0
) (
    input  logic [3:0] code_i,
    output logic [6:0] seg_o
);
    logic [6:0] pat_al;

    // Active-low decode of one decimal digit
    always_comb begin
        case (code_i)
            4'd0:    pat_al = 7'b0000001;
            4'd1:    pat_al = 7'b1001111;
            4'd2:    pat_al = 7'b0010010;
            4'd3:    pat_al = 7'b0000110;
            4'd4:    pat_al = 7'b1001100;
            4'd5:    pat_al = 7'b0100100;
            4'd6:    pat_al = 7'b0100000;
            4'd7:    pat_al = 7'b0001111;
            4'd8:    pat_al = 7'b0000000;
            4'd9:    pat_al = 7'b0000100;
            default: pat_al = GLYPH_OFF_AL;
        endcase
    end

    // Polarity variant chosen at elaboration
    if (POL != 0) begin : g_cc
        assign seg_o = ~pat_al;
    end else begin : g_ca
        assign seg_o = pat_al;
    end

endmodule

// File: rtl/sevseg_int_driver.sv
// Top: multi-digit seven-segment decimal driver.
// Does: converts value_i to BCD sequentially, suppresses leading zeros,
// maps every digit to segments and registers the segment buses.
// Assumes: synchronous active-low reset; BIN_W derived from DIGITS.
module sevseg_int_driver
    import sevseg_pkg::*;
#(
    parameter int DIGITS = 3,
    parameter int POL    = 0,
    parameter int BIN_W  = sevseg_pkg::bin_width(DIGITS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [BIN_W-1:0]      value_i,
    output logic [7*DIGITS-1:0]   seg_o
);
    localparam logic [6:0] OFF_PIN = (POL != 0) ? ~GLYPH_OFF_AL : GLYPH_OFF_AL;

    logic [4*DIGITS-1:0] bcd_raw;
    logic [4*DIGITS-1:0] bcd_shown;
    logic [7*DIGITS-1:0] seg_next;
    logic [7*DIGITS-1:0] seg_q;
    logic                conv_busy;
    logic                conv_done;

    sevseg_bin2bcd #(.DIGITS(DIGITS), .BIN_W(BIN_W)) u_conv (
        .clk     (clk),
        .rst_n   (rst_n),
        .value_i (value_i),
        .bcd_o   (bcd_raw),
        .busy_o  (conv_busy),
        .done_o  (conv_done)
    );

    sevseg_zero_blank #(.DIGITS(DIGITS)) u_blank (
        .bcd_i (bcd_raw),
        .bcd_o (bcd_shown)
    );

    for (genvar d = 0; d < DIGITS; d++) begin : g_digit
        sevseg_glyph #(.POL(POL)) u_glyph (
            .code_i (bcd_shown[4*d +: 4]),
            .seg_o  (seg_next[7*d +: 7])
        );
    end

    // Output register: unlit in reset, otherwise the mapped result
    always_ff @(posedge clk) begin
        if (!rst_n) seg_q <= {DIGITS{OFF_PIN}};
        else        seg_q <= seg_next;
    end

    assign seg_o = seg_q;

endmodule

// File: rtl/sevseg_int_driver_chk.sv
// Checker for sevseg_int_driver, attached by bind.
// Does: checks reset blanking, conversion length, output update timing,
// digit-0 visibility and the suppression ordering.
// Assumes: reset held low for at least two cycles.
module sevseg_int_driver_chk #(
    parameter int DIGITS = 3,
    parameter int POL    = 0,
    parameter int BIN_W  = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic [7*DIGITS-1:0] seg_o,
    input logic                busy,
    input logic                done
);
    localparam logic [6:0] OFF7 = (POL != 0) ? 7'b0000000 : 7'b1111111;
    localparam int         CW   = $clog2(BIN_W + 4);

    logic [CW-1:0] busy_len_q;
    logic          rst_seen_q;

    // Count the cycles the converter stays busy
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_len_q <= '0;
        else if (busy) busy_len_q <= busy_len_q + 1'b1;
        else           busy_len_q <= '0;
    end

    // Remember that the last edge sampled reset
    always_ff @(posedge clk) rst_seen_q <= !rst_n;

    // R7: after a reset edge every digit is unlit
    always @(negedge clk) begin
        if (rst_seen_q)
            assert_reset_blank_R7: assert (seg_o == {DIGITS{OFF7}});
    end

    // R5: a conversion occupies BIN_W+1 busy cycles
    assert_conv_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && $past(rst_n)) |-> (busy_len_q == CW'(BIN_W + 1)));

    // R5: outputs move only two edges after a finishing cycle
    assert_update_timing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(seg_o) && $past(rst_n)) |-> $past(done, 2));

    // R4: digit 0 is lit once a result is published
    assert_lsd_lit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ##2 (seg_o[6:0] != OFF7));

    // R8: leaving reset starts a conversion at once
    assert_start_after_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |=> busy);

    // R3: an unlit digit above digit 0 implies every higher digit is unlit
    for (genvar i = 1; i < DIGITS - 1; i++) begin : g_order
        assert_blank_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (seg_o[7*i +: 7] == OFF7) |-> (seg_o[7*(i+1) +: 7] == OFF7));
    end

endmodule

bind sevseg_int_driver sevseg_int_driver_chk #(
    .DIGITS (DIGITS),
    .POL    (POL),
    .BIN_W  (BIN_W)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .seg_o (seg_o),
    .busy  (conv_busy),
    .done  (conv_done)
);

// File: tb/tb_sevseg_int_driver.sv
module tb_sevseg_int_driver;
    localparam int DIGITS = 3;
    localparam int BIN_W  = 10;
    localparam int SW     = 7 * DIGITS;
    localparam int NVEC   = 10;
    localparam int VEC [NVEC] = '{62, 7, 10, 99, 100, 305, 999, 480, 5, 0};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [BIN_W-1:0] value = '0;
    logic [SW-1:0]    seg_ca;
    logic [SW-1:0]    seg_cc;
    int               errors = 0;
    int               checks = 0;
    int               cycles = 0;

    always #2 clk = ~clk;   // 250 MHz

    sevseg_int_driver #(.DIGITS(DIGITS), .POL(0)) dut (
        .clk(clk), .rst_n(rst_n), .value_i(value), .seg_o(seg_ca));
    sevseg_int_driver #(.DIGITS(DIGITS), .POL(1)) dut_cc (
        .clk(clk), .rst_n(rst_n), .value_i(value), .seg_o(seg_cc));

    // R2 glyph table, active low, a in bit 6
    function automatic logic [6:0] glyph(input int d);
        case (d)
            0: return 7'b0000001;  1: return 7'b1001111;
            2: return 7'b0010010;  3: return 7'b0000110;
            4: return 7'b1001100;  5: return 7'b0100100;
            6: return 7'b0100000;  7: return 7'b0001111;
            8: return 7'b0000000;  9: return 7'b0000100;
            default: return 7'b1111111;
        endcase
    endfunction

    // R1/R3/R4: expected common-anode buses for a value
    function automatic logic [SW-1:0] expect_seg(input int v);
        logic [SW-1:0] r;
        int p = 1;
        for (int i = 0; i < DIGITS; i++) begin
            if (i > 0 && v < p) r[7*i +: 7] = 7'b1111111;
            else                r[7*i +: 7] = glyph((v / p) % 10);
            p = p * 10;
        end
        return r;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [SW-1:0] exp_ca);
        checks++;
        if (seg_ca !== exp_ca) begin
            errors++;
            $display("FAIL %s: seg_o=%b expected %b", req, seg_ca, exp_ca);
        end
        checks++;
        if (seg_cc !== ~exp_ca) begin
            errors++;
            $display("FAIL R9 (%s): inverted seg_o=%b expected %b", req, seg_cc, ~exp_ca);
        end
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
            summary();
        end
    end

    initial begin
        logic [SW-1:0] prev;
        tick(3);
        chk("R7 reset blank", {DIGITS{7'b1111111}});
        rst_n = 1'b1;                       // R8: conversion of 0 starts now
        tick(BIN_W + 2);
        chk("R8 still blank before deadline", {DIGITS{7'b1111111}});
        tick(1);
        chk("R4 zero shows single digit", expect_seg(0));
        prev = expect_seg(0);

        // Vector table walk: R1, R2, R3, R5
        for (int i = 0; i < NVEC; i++) begin
            value = BIN_W'(VEC[i]);
            tick(BIN_W + 2);
            chk("R5 old result held", prev);
            tick(1);
            chk("R1 R3 decimal result", expect_seg(VEC[i]));
            prev = expect_seg(VEC[i]);
        end

        // R6: input moves during a conversion
        value = 10'd123;
        tick(3);
        value = 10'd456;
        tick(BIN_W - 1);
        chk("R6 old held", prev);
        tick(1);
        chk("R6 captured value", expect_seg(123));
        tick(BIN_W + 1);
        chk("R6 first result held", expect_seg(123));
        tick(1);
        chk("R6 follow-up conversion", expect_seg(456));

        // R7/R8: reset in the middle of a conversion
        value = 10'd305;
        tick(4);
        rst_n = 1'b0;
        tick(2);
        chk("R7 mid-conversion reset", {DIGITS{7'b1111111}});
        rst_n = 1'b1;
        tick(BIN_W + 2);
        chk("R8 blank until deadline", {DIGITS{7'b1111111}});
        tick(1);
        chk("R8 restart after reset", expect_seg(305));

        // R3: single suppressed digit and full width
        value = 10'd40;
        tick(BIN_W + 3);
        chk("R3 two digits", expect_seg(40));
        value = 10'd808;
        tick(BIN_W + 3);
        chk("R3 inner zero kept", expect_seg(808));

        summary();
    end
endmodule